// File: doc/BRIEF.md
# Two-Level Bus Address Translator

This block turns 32-bit device bus addresses into physical addresses for a chip's I/O path. Translation uses 4 KB pages. The first table level sits in on-chip registers, one register for each 32 MB slice of bus space. A first-level register either maps its whole slice directly as a big page or points at a second-level table in memory. Second-level entries are fetched through a simple one-word read port, and a small fully associative cache keeps the most recent page translations.

A requester presents one bus address and holds it until a one-cycle response pulse arrives. The response carries the physical address, a cached flag, a priority flag and a fault flag. Translation can be switched off entirely, and a programmable window limits which bus addresses are translated. Software keeps the cache coherent by writing a 16 KB-granular key to an invalidate register.

Top module: `iox_xlate`

## Requirements
- R1: After reset rsp_valid and mem_req are low, and every register reads back as zero.
- R2: Register map: addresses 0 to 63 hold the first-level entries as full 32-bit words. Address 64 is the control register, whose only stored bit is bit 8 (translate enable). Address 65 holds the 2-bit window code in bits 1:0. Address 66 is the invalidate register, which always reads zero. Bits that are not stored read zero.
- R3: With enable clear, an accepted request returns rsp_paddr equal to the zero-extended bus address, with cached, priority and fault all clear. No memory read is made, and rsp_valid rises one cycle after acceptance.
- R4: Window codes are 0 for addresses below 2^28, 1 for addresses below 2^31, and 2 or 3 for the full 32-bit space. A bus address outside the window passes through as in R3.
- R5: Bit 31 set in the selected first-level entry (index = bus bits 30:25) marks a big page. rsp_paddr is then entry bits 29:13 followed by bus bits 24:0, cached is entry bit 1 and priority is entry bit 0. No memory read is made.
- R6: A fault is returned, with rsp_paddr equal to the zero-extended bus address, in two cases: the first-level entry has neither bit 31 nor bit 30 set, or bus bit 31 is set inside the window.
- R7: With bit 30 set and bit 31 clear, a cache miss makes exactly one single-cycle mem_req at address (entry bits 29:0 shifted left by 12) plus 4 times bus bits 24:12. If the returned word has bit 31 set, rsp_paddr is word bits 29:0 followed by bus bits 11:0, cached is word bit 30, and rsp_valid rises the cycle after mem_rsp_valid.
- R8: A returned second-level word with bit 31 clear gives a fault and is not cached, so the same request reads memory again.
- R9: A request whose 4 KB page is in the cache responds one cycle after acceptance with the cached result and makes no memory read.
- R10: Writing V to the invalidate register drops every cached page whose bus address shifted right by 14 equals V. Other pages stay cached.
- R11: The cache holds 8 pages and fills slots in round-robin order, so the ninth distinct fill evicts the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| req_valid | input | 1 | Translation request, held until the response pulse |
| req_addr | input | 32 | Bus address to translate |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_fault | output | 1 | Translation fault |
| rsp_cached | output | 1 | Cached attribute of the page |
| rsp_prio | output | 1 | Priority attribute (big pages only) |
| rsp_paddr | output | 42 | Physical address, or the bus address on a fault |
| mem_req | output | 1 | One-cycle read request for a second-level word |
| mem_addr | output | 42 | Physical address of that word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Second-level word |

## Verification
The bench builds the block with its default parameters: 64 first-level slices of 32 MB, an 8-entry cache and 30-bit page numbers. With these values the slice index covers bus bits 30:25, so a bus address with bit 31 set under the widest window reaches the beyond-table fault. Eight cache slots are few enough that ten distinct page fills wrap the round-robin pointer and evict live entries. Several pages also share one 16 KB invalidate key, so a single invalidate write is seen to drop a group of pages while pages with other keys stay cached.

// File: rtl/iox_pkg.sv
package iox_pkg;
   // first-level entry flag positions
   localparam int unsigned L1_BIG_BIT  = 31;
   localparam int unsigned L1_PTR_BIT  = 30;
   localparam int unsigned L1_CACH_BIT = 1;
   localparam int unsigned L1_PRIO_BIT = 0;
   // second-level entry flag positions
   localparam int unsigned L2_VLD_BIT  = 31;
   localparam int unsigned L2_CACH_BIT = 30;
   // control register enable position
   localparam int unsigned CTRL_EN_BIT = 8;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WALK = 2'd1,
      ST_DONE = 2'd2
   } walk_st_e;
endpackage

// File: rtl/iox_regs.sv
module iox_regs #(
   parameter int unsigned L1_N   = 64,
   parameter int unsigned IDX_W  = $clog2(L1_N),
   parameter int unsigned REG_AW = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [REG_AW-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   input  logic [IDX_W-1:0]  l1_idx,
   output logic [31:0]       l1_entry,
   output logic              xlate_en,
   output logic [1:0]        win_code,
   output logic              inv_we,
   output logic [31:0]       inv_key
);
   import iox_pkg::*;

   localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(L1_N);
   localparam logic [REG_AW-1:0] A_WIN  = REG_AW'(L1_N + 1);
   localparam logic [REG_AW-1:0] A_INV  = REG_AW'(L1_N + 2);

   logic [31:0] l1_q [L1_N];
   logic        en_q;
   logic [1:0]  win_q;
   logic        in_table;

   assign in_table = (addr[REG_AW-1] == 1'b0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < L1_N; i++) l1_q[i] <= '0;
         en_q  <= 1'b0;
         win_q <= 2'd0;
      end else if (we) begin
         if (in_table) l1_q[addr[IDX_W-1:0]] <= wdata;
         if (addr == A_CTRL) en_q <= wdata[CTRL_EN_BIT];
         if (addr == A_WIN) win_q <= wdata[1:0];
      end
   end

   always_comb begin
      rdata = '0;
      if (in_table)            rdata = l1_q[addr[IDX_W-1:0]];
      else if (addr == A_CTRL) rdata[CTRL_EN_BIT] = en_q;
      else if (addr == A_WIN)  rdata[1:0] = win_q;
   end

   assign l1_entry = l1_q[l1_idx];
   assign xlate_en = en_q;
   assign win_code = win_q;
   assign inv_we   = we && (addr == A_INV);
   assign inv_key  = wdata;

   // R2: the control register stores nothing but the enable bit
   a_r2_ctrl_stored: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == A_CTRL) |=> (xlate_en == $past(wdata[CTRL_EN_BIT])));
endmodule

// File: rtl/iox_tlb.sv
module iox_tlb #(
   parameter int unsigned N     = 8,
   parameter int unsigned VPN_W = 20,
   parameter int unsigned PPN_W = 30,
   parameter int unsigned KEY_SH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VPN_W-1:0] look_vpn,
   output logic             hit,
   output logic [PPN_W-1:0] hit_ppn,
   output logic             hit_cached,
   input  logic             fill,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PPN_W-1:0] fill_ppn,
   input  logic             fill_cached,
   input  logic             inv,
   input  logic [31:0]      inv_key
);
   localparam int unsigned PW = (N > 1) ? $clog2(N) : 1;

   logic [N-1:0]     vld;
   logic [VPN_W-1:0] tag   [N];
   logic [PPN_W-1:0] ppn   [N];
   logic [N-1:0]     cach;
   logic [N-1:0]     match;
   logic [N-1:0]     kill;
   logic [PW-1:0]    ptr;
   logic             fill_dead;

   generate
      for (genvar g = 0; g < N; g++) begin : g_lane
         assign match[g] = vld[g] && (tag[g] == look_vpn);
         assign kill[g]  = inv && vld[g] && (32'(tag[g] >> KEY_SH) == inv_key);
      end
   endgenerate

   always_comb begin
      hit_ppn    = '0;
      hit_cached = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (match[i]) begin
            hit_ppn    = hit_ppn | ppn[i];
            hit_cached = hit_cached | cach[i];
         end
      end
   end
   assign hit = |match;

   // an invalidate in the fill cycle that covers the new page wins
   assign fill_dead = inv && (32'(fill_vpn >> KEY_SH) == inv_key);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= '0;
         ptr <= '0;
      end else begin
         vld <= vld & ~kill;
         if (fill) begin
            vld[ptr] <= !fill_dead;
            ptr      <= (ptr == PW'(N - 1)) ? '0 : ptr + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (fill) begin
         tag[ptr]  <= fill_vpn;
         ppn[ptr]  <= fill_ppn;
         cach[ptr] <= fill_cached;
      end
   end

   // R11: never two slots holding the same page
   a_r11_unique_hit: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));
   // R10: an invalidate removes every matching slot it names
   a_r10_inv_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (inv && !fill) |=> ((vld & $past(kill)) == '0));
   // R11: a surviving fill occupies the slot the pointer named
   a_r11_fill_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (fill && !fill_dead) |=> vld[$past(ptr)]);
endmodule

// File: rtl/iox_xlate.sv
module iox_xlate #(
   parameter int unsigned PPN_W    = 30,
   parameter int unsigned L1_N     = 64,
   parameter int unsigned TLB_N    = 8,
   parameter int unsigned SLICE_SH = 25,
   localparam int unsigned IDX_W    = $clog2(L1_N),
   localparam int unsigned REG_AW   = IDX_W + 1,
   localparam int unsigned PA_W     = PPN_W + 12,
   localparam int unsigned VPN_W    = 20,
   localparam int unsigned L2_IDX_W = SLICE_SH - 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              req_valid,
   input  logic [31:0]       req_addr,
   output logic              rsp_valid,
   output logic              rsp_fault,
   output logic              rsp_cached,
   output logic              rsp_prio,
   output logic [PA_W-1:0]   rsp_paddr,
   output logic              mem_req,
   output logic [PA_W-1:0]   mem_addr,
   input  logic              mem_rsp_valid,
   input  logic [31:0]       mem_rsp_data
);
   import iox_pkg::*;

   // elaboration-time parameter checks
   generate
      if ((1 << IDX_W) != L1_N) begin : g_bad_l1n
         $error("L1_N must be a power of two");
      end
      if (IDX_W + SLICE_SH > 32) begin : g_bad_span
         $error("first-level slices exceed the 32-bit bus space");
      end
      if (PPN_W > 30 || PPN_W <= L2_IDX_W) begin : g_bad_ppn
         $error("PPN_W must fit entry bits 29:0 and exceed the slice index");
      end
      if (TLB_N < 1) begin : g_bad_tlb
         $error("TLB_N must be at least one");
      end
   endgenerate

   logic [31:0]      l1_entry;
   logic             xlate_en;
   logic [1:0]       win_code;
   logic             inv_we;
   logic [31:0]      inv_key;
   logic             tlb_hit;
   logic [PPN_W-1:0] tlb_ppn;
   logic             tlb_cached;
   logic             tlb_fill;
   logic             win_ok;
   logic             beyond;
   logic [PA_W-1:0]  pass_addr;
   logic [PA_W-1:0]  big_addr;
   logic [PA_W-1:0]  walk_addr;
   logic [31:0]      q_addr;
   walk_st_e         st;

   iox_regs #(.L1_N(L1_N), .IDX_W(IDX_W), .REG_AW(REG_AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata),
      .l1_idx(req_addr[SLICE_SH +: IDX_W]), .l1_entry(l1_entry),
      .xlate_en(xlate_en), .win_code(win_code),
      .inv_we(inv_we), .inv_key(inv_key));

   assign tlb_fill = (st == ST_WALK) && mem_rsp_valid && mem_rsp_data[L2_VLD_BIT];

   iox_tlb #(.N(TLB_N), .VPN_W(VPN_W), .PPN_W(PPN_W), .KEY_SH(2)) u_tlb (
      .clk(clk), .rst_n(rst_n),
      .look_vpn(req_addr[31:12]), .hit(tlb_hit), .hit_ppn(tlb_ppn),
      .hit_cached(tlb_cached),
      .fill(tlb_fill), .fill_vpn(q_addr[31:12]),
      .fill_ppn(mem_rsp_data[PPN_W-1:0]),
      .fill_cached(mem_rsp_data[L2_CACH_BIT]),
      .inv(inv_we), .inv_key(inv_key));

   always_comb begin
      case (win_code)
         2'd0:    win_ok = (req_addr[31:28] == 4'd0);
         2'd1:    win_ok = !req_addr[31];
         default: win_ok = 1'b1;
      endcase
   end

   generate
      if (IDX_W + SLICE_SH < 32) begin : g_beyond
         assign beyond = |req_addr[31:IDX_W+SLICE_SH];
      end else begin : g_full
         assign beyond = 1'b0;
      end
   endgenerate

   assign pass_addr = PA_W'(req_addr);
   assign big_addr  = {l1_entry[PPN_W-1:L2_IDX_W], req_addr[SLICE_SH-1:0]};
   assign walk_addr = PA_W'({l1_entry[PPN_W-1:0], 12'h000})
                    + PA_W'({req_addr[SLICE_SH-1:12], 2'b00});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         q_addr     <= '0;
         rsp_valid  <= 1'b0;
         rsp_fault  <= 1'b0;
         rsp_cached <= 1'b0;
         rsp_prio   <= 1'b0;
         rsp_paddr  <= '0;
         mem_req    <= 1'b0;
         mem_addr   <= '0;
      end else begin
         rsp_valid <= 1'b0;
         mem_req   <= 1'b0;
         case (st)
            ST_IDLE: if (req_valid) begin
               q_addr     <= req_addr;
               rsp_fault  <= 1'b0;
               rsp_cached <= 1'b0;
               rsp_prio   <= 1'b0;
               rsp_paddr  <= pass_addr;
               st         <= ST_DONE;
               rsp_valid  <= 1'b1;
               if (!xlate_en || !win_ok) begin
                  // untranslated pass-through
               end else if (beyond) begin
                  rsp_fault <= 1'b1;
               end else if (l1_entry[L1_BIG_BIT]) begin
                  rsp_paddr  <= big_addr;
                  rsp_cached <= l1_entry[L1_CACH_BIT];
                  rsp_prio   <= l1_entry[L1_PRIO_BIT];
               end else if (l1_entry[L1_PTR_BIT]) begin
                  if (tlb_hit) begin
                     rsp_paddr  <= {tlb_ppn, req_addr[11:0]};
                     rsp_cached <= tlb_cached;
                  end else begin
                     rsp_valid <= 1'b0;
                     mem_req   <= 1'b1;
                     mem_addr  <= walk_addr;
                     st        <= ST_WALK;
                  end
               end else begin
                  rsp_fault <= 1'b1;
               end
            end
            ST_WALK: if (mem_rsp_valid) begin
               rsp_valid <= 1'b1;
               st        <= ST_DONE;
               if (mem_rsp_data[L2_VLD_BIT]) begin
                  rsp_paddr  <= {mem_rsp_data[PPN_W-1:0], q_addr[11:0]};
                  rsp_cached <= mem_rsp_data[L2_CACH_BIT];
               end else begin
                  rsp_fault <= 1'b1;
                  rsp_paddr <= PA_W'(q_addr);
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   logic unused_bits;
   assign unused_bits = ^{l1_entry[29:PPN_W], mem_rsp_data[29:PPN_W]};

   // R7: a table read lasts one cycle
   a_r7_single_read: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);
   // R7: reads only while a walk is pending
   a_r7_read_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (st == ST_WALK));
   // R9: the response is a single pulse
   a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   // R6: a fault carries no attributes
   a_r6_fault_bare: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (!rsp_cached && !rsp_prio));
   // R8: an invalid second-level word never fills the cache
   a_r8_no_fill_bad: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rsp_valid && !mem_rsp_data[L2_VLD_BIT]) |-> !tlb_fill);
endmodule

// File: tb/sim_iox_xlate.sv
module sim_iox_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [6:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        rsp_valid, rsp_fault, rsp_cached, rsp_prio;
   logic [41:0] rsp_paddr;
   logic        mem_req;
   logic [41:0] mem_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;

   int errors = 0;
   int checks = 0;
   int reads  = 0;
   logic [41:0] last_mem_addr = '0;
   logic [41:0] bad_addr = '1;
   bit   in_req = 1'b0;

   // reference model state
   logic [31:0] m_l1 [64];
   bit          m_en = 0;
   logic [1:0]  m_win = 0;
   bit          m_vld [8];
   logic [19:0] m_vpn [8];
   logic [29:0] m_ppn [8];
   bit          m_c   [8];
   int          m_ptr = 0;

   always #5 clk = ~clk;

   iox_xlate u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .req_valid(req_valid), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cached(rsp_cached),
      .rsp_prio(rsp_prio), .rsp_paddr(rsp_paddr),
      .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data));

   function automatic logic [31:0] mem_word(input logic [41:0] a);
      logic [29:0] r;
      r = 30'(a[31:2]) * 30'd3 + 30'd7;
      if (a == bad_addr) return {2'b00, r};
      return {1'b1, a[4], r};
   endfunction

   // memory: answers 3 ns after the edge that raised mem_req
   always @(posedge clk) begin
      #3;
      mem_rsp_valid = 1'b0;
      if (mem_req) begin
         reads++;
         last_mem_addr = mem_addr;
         mem_rsp_data  = mem_word(mem_addr);
         mem_rsp_valid = 1'b1;
      end
   end

   // every clock: no response or read outside a request
   always @(negedge clk) begin
      if (rst_n && !in_req && (rsp_valid || mem_req)) begin
         errors++;
         $display("FAIL R9 stray activity rsp_valid=%0b mem_req=%0b expected 0/0",
                  rsp_valid, mem_req);
      end
   end

   task automatic check(input string tag, input bit ok, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
      if (a < 7'd64) m_l1[a[5:0]] = d;
      else if (a == 7'd64) m_en = d[8];
      else if (a == 7'd65) m_win = d[1:0];
      else if (a == 7'd66)
         for (int k = 0; k < 8; k++)
            if (m_vld[k] && 32'(m_vpn[k] >> 2) == d) m_vld[k] = 0;
   endtask

   task automatic rd_check(input string tag, input logic [6:0] a, input logic [31:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(tag, reg_rdata == exp, "rdata", 64'(reg_rdata), 64'(exp));
   endtask

   task automatic xlate(input string tag, input logic [31:0] a);
      logic [41:0] ep = {10'b0, a};
      logic [41:0] ta = '0;
      logic [31:0] l1 = m_l1[a[30:25]];
      logic [31:0] w;
      bit ef = 0, ec = 0, epr = 0, win_ok, hit = 0;
      int er = 0, lat = 1, r0, cyc = 0;
      case (m_win)
         2'd0:    win_ok = (a < 32'h1000_0000);
         2'd1:    win_ok = (a < 32'h8000_0000);
         default: win_ok = 1;
      endcase
      if (!m_en || !win_ok) begin
      end else if (a[31]) ef = 1;
      else if (l1[31]) begin
         ep = {l1[29:13], a[24:0]}; ec = l1[1]; epr = l1[0];
      end else if (l1[30]) begin
         for (int k = 0; k < 8; k++)
            if (m_vld[k] && m_vpn[k] == a[31:12]) begin
               hit = 1; ep = {m_ppn[k], a[11:0]}; ec = m_c[k];
            end
         if (!hit) begin
            er = 1; lat = 2;
            ta = {l1[29:0], 12'h000} + (42'(a[24:12]) << 2);
            w = mem_word(ta);
            if (w[31]) begin
               ep = {w[29:0], a[11:0]}; ec = w[30];
               m_vld[m_ptr] = 1; m_vpn[m_ptr] = a[31:12];
               m_ppn[m_ptr] = w[29:0]; m_c[m_ptr] = w[30];
               m_ptr = (m_ptr + 1) % 8;
            end else ef = 1;
         end
      end else ef = 1;
      if (ef) begin ec = 0; epr = 0; end
      @(negedge clk);
      r0 = reads; in_req = 1; req_valid = 1'b1; req_addr = a;
      do begin
         @(negedge clk);
         cyc++;
      end while (!rsp_valid && cyc < 20);
      req_valid = 1'b0;
      check(tag, rsp_valid, "response missing", 64'(rsp_valid), 64'd1);
      check(tag, cyc == lat, "latency", 64'(cyc), 64'(lat));
      check(tag, rsp_fault == ef && rsp_cached == ec && rsp_prio == epr,
            "fault/cached/prio", {61'b0, rsp_fault, rsp_cached, rsp_prio},
            {61'b0, ef, ec, epr});
      check(tag, rsp_paddr == ep, "paddr", 64'(rsp_paddr), 64'(ep));
      check(tag, (reads - r0) == er, "memory reads", 64'(reads - r0), 64'(er));
      if (er == 1)
         check(tag, last_mem_addr == ta, "read address", 64'(last_mem_addr), 64'(ta));
      @(negedge clk);
      in_req = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 64; i++) m_l1[i] = '0;
      for (int k = 0; k < 8; k++) m_vld[k] = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", !rsp_valid && !mem_req, "outputs after reset",
            {62'b0, rsp_valid, mem_req}, 64'd0);
      rd_check("R1", 7'd64, 32'h0);
      rd_check("R1", 7'd5, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      // R3: translation disabled
      xlate("R3", 32'h1234_5678);
      // R2: register map
      wr(7'd0, 32'h4000_0100);
      wr(7'd1, 32'h9555_4003);
      wr(7'd2, 32'h0000_0000);
      wr(7'd64, 32'hFFFF_FFFF);
      wr(7'd65, 32'hFFFF_FFFD);
      rd_check("R2", 7'd0, 32'h4000_0100);
      rd_check("R2", 7'd64, 32'h0000_0100);
      rd_check("R2", 7'd65, 32'h0000_0001);
      rd_check("R2", 7'd66, 32'h0000_0000);
      // R7 miss then R9 hit on the same page
      xlate("R7", 32'h0000_3ABC);
      xlate("R9", 32'h0000_3004);
      // R5 big page
      xlate("R5", 32'h0234_5678);
      // R6 empty first-level entry
      xlate("R6", 32'h0400_0010);
      // R4 window codes
      wr(7'd65, 32'h0);
      xlate("R4", 32'h1000_0000);
      xlate("R4", 32'h0FFF_F000);
      wr(7'd65, 32'h1);
      xlate("R4", 32'h8000_0000);
      wr(7'd65, 32'h3);
      xlate("R6", 32'h8000_0000);
      wr(7'd65, 32'h2);
      xlate("R6", 32'hC000_1000);
      wr(7'd65, 32'h1);
      // R8 invalid second-level word, not cached
      bad_addr = 42'h10_0014;
      xlate("R8", 32'h0000_5000);
      xlate("R8", 32'h0000_5FF0);
      bad_addr = '1;
      // R10 invalidate by 16 KB key
      xlate("R10", 32'h0000_4000);
      xlate("R10", 32'h0000_6000);
      xlate("R10", 32'h0000_8000);
      wr(7'd66, 32'h1);
      xlate("R10", 32'h0000_4000);
      xlate("R10", 32'h0000_6000);
      xlate("R10", 32'h0000_8000);
      // R11 round robin over ten distinct pages, then revisit
      for (int p = 0; p < 10; p++) xlate("R11", 32'h0001_0000 + 32'(p) * 32'h1000);
      for (int p = 0; p < 10; p++) xlate("R11", 32'h0001_0040 + 32'(p) * 32'h1000);
      // R3 again: disable after the cache holds pages
      wr(7'd64, 32'h0);
      xlate("R3", 32'h0001_0040);
      finish_run();
   end
endmodule